// File: doc/BRIEF.md
# Transmit Flow-Control Credit Tracker

This block keeps count of the transmit flow-control credits a PCI Express transmitter may still spend toward its link partner. Three transaction classes are tracked: posted, non-posted and completion. Each class has one counter for header credits and one for data credits. A data credit covers four dwords (sixteen bytes) of payload. The counters start from the limits given when flow-control initialization finishes. They grow with the update amounts returned by the partner and shrink as the transmit path reports packets sent.

The block drives a 36-bit packed view of the credits still available. Each field saturates at its own maximum and stays there until enough credits have been spent for the true count to fit. It also drives two flags for a non-posted limit that started at exactly one credit. Two sticky violation flags record that the transmit path spent more non-posted credits than were shown to it. Each counter holds its limit and its consumed total at a fixed width. Available credit is the difference of the two, taken modulo that width.

Top module: `tx_credit_tracker`

## Requirements
- R1: During and after reset, `cred_view` is all zero and all four flags are low.
- R2: Until the first `init_valid` pulse, update and consumption events are ignored: `cred_view` stays zero and no violation flag rises.
- R3: An `init_valid` pulse loads each class's header and data limits and clears its consumed totals. Class code 0 is posted, 1 is non-posted and 2 is completion. The limit inputs hold class c at slice `[c*W +: W]`. In `cred_view`, class c occupies bits `[12c+11:12c]`, with the header field in bits `[12c+3:12c]` and the data field in bits `[12c+11:12c+4]`. The view reflects an event two clock edges after the cycle in which the event is presented.
- R4: A consumption event spends one header credit and ceil(`use_len_dw`/4) data credits of the class in `use_class`. A length of zero spends no data credit. Class code 3 changes nothing.
- R5: An update event adds `upd_hdr` and `upd_dat` to the limits of class `upd_class`. An update and a consumption in the same cycle both take effect, whether they name the same class or different classes.
- R6: Each view field shows min(available, field maximum), where the maximum is 15 for header fields and 255 for data fields.
- R7: At each `init_valid` pulse, `np_hdr_one` and `np_dat_one` are set if the non-posted header or data limit, respectively, equals 1, and cleared otherwise. They do not change between pulses.
- R8: A non-posted consumption raises `np_hdr_viol` when the saturated non-posted header count available in that cycle is 0. It raises `np_dat_viol` when its data cost exceeds the saturated non-posted data count available in that cycle. Both flags stay high until reset, and a new `init_valid` pulse does not clear them.
- R9: When `init_valid` coincides with an update or a consumption, the initialization wins and the other events of that cycle are dropped.
- R10: Counters wrap modulo 2^8 for headers and 2^12 for data. Spending past the limit therefore gives a large available count, and the field shows its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_valid | input | 1 | Flow-control initialization done; loads limits |
| init_hdr_lim | input | 24 | Initial header limits, 8 bits per class |
| init_dat_lim | input | 36 | Initial data limits, 12 bits per class |
| upd_valid | input | 1 | Credit update from the link partner |
| upd_class | input | 2 | Class of the update |
| upd_hdr | input | 8 | Header credits returned |
| upd_dat | input | 12 | Data credits returned |
| use_valid | input | 1 | Packet sent by the transmit path |
| use_class | input | 2 | Class of the packet sent |
| use_len_dw | input | 10 | Payload length of that packet in dwords |
| cred_view | output | 36 | Packed saturated available credits |
| np_hdr_one | output | 1 | Non-posted header limit started at one |
| np_dat_one | output | 1 | Non-posted data limit started at one |
| np_hdr_viol | output | 1 | Sticky non-posted header overspend |
| np_dat_viol | output | 1 | Sticky non-posted data overspend |

## Verification
A returned credit update and a consumption can land in the same cycle, on the same class or on different ones. An initialization can also collide with either. The random phase draws update and consumption strobes independently each cycle, so both orders of overlap occur often. Directed steps force the same-class collision and the collision with initialization. A bench model applies both events, or only the initialization, to its own counters, and every cycle it compares the predicted saturated view and flags with the outputs.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
   localparam int NUM_CLASS = 3;

   typedef enum logic [1:0] {
      CLS_POST    = 2'd0,
      CLS_NONPOST = 2'd1,
      CLS_CPL     = 2'd2,
      CLS_NONE    = 2'd3
   } tc_class_e;
endpackage

// File: rtl/tcf_cost.sv
// Converts a payload length in dwords into data credits, rounding up.
module tcf_cost #(
   parameter int LEN_W         = 10,
   parameter int CNT_W         = 12,
   parameter int DW_PER_CREDIT = 4
) (
   input  logic [LEN_W-1:0] len_dw,
   output logic [CNT_W-1:0] cost
);
   localparam int SHIFT = $clog2(DW_PER_CREDIT);

   if ((1 << SHIFT) != DW_PER_CREDIT) begin : g_bad_unit
      $error("DW_PER_CREDIT must be a power of two");
   end
   if (CNT_W < LEN_W + 1 - SHIFT) begin : g_bad_width
      $error("CNT_W too narrow for the largest packet cost");
   end

   if (SHIFT == 0) begin : g_unit
      assign cost = CNT_W'(len_dw);
   end else begin : g_round
      logic [LEN_W:0] padded;
      assign padded = {1'b0, len_dw} + (LEN_W+1)'(DW_PER_CREDIT - 1);
      assign cost   = CNT_W'(padded >> SHIFT);
   end
endmodule

// File: rtl/tcf_counter.sv
// One credit counter: limit and consumed totals, modular difference,
// saturated field and its registered copy.
module tcf_counter #(
   parameter int CNT_W = 8,
   parameter int FLD_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             add_en,
   input  logic [CNT_W-1:0] add_val,
   input  logic             sub_en,
   input  logic [CNT_W-1:0] sub_val,
   output logic [FLD_W-1:0] shown,
   output logic [FLD_W-1:0] view_q
);
   if (FLD_W > CNT_W) begin : g_bad_field
      $error("field wider than its counter");
   end

   logic [CNT_W-1:0] lim_q;
   logic [CNT_W-1:0] used_q;
   logic [CNT_W-1:0] avail;

   assign avail = lim_q - used_q;

   if (FLD_W == CNT_W) begin : g_full
      assign shown = avail;
   end else begin : g_sat
      localparam logic [CNT_W-1:0] FLD_MAX = CNT_W'((64'd1 << FLD_W) - 64'd1);
      assign shown = (avail > FLD_MAX) ? {FLD_W{1'b1}} : avail[FLD_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lim_q  <= '0;
         used_q <= '0;
         view_q <= '0;
      end else begin
         if (load) begin
            lim_q  <= load_val;
            used_q <= '0;
         end else begin
            if (add_en) lim_q  <= lim_q + add_val;
            if (sub_en) used_q <= used_q + sub_val;
         end
         view_q <= shown;
      end
   end
endmodule

// File: rtl/tcf_np_monitor.sv
// Single-credit limit flags and sticky overspend flags for non-posted traffic.
module tcf_np_monitor #(
   parameter int HDR_CNT_W = 8,
   parameter int DAT_CNT_W = 12,
   parameter int HDR_FLD_W = 4,
   parameter int DAT_FLD_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 init_valid,
   input  logic [HDR_CNT_W-1:0] init_hdr,
   input  logic [DAT_CNT_W-1:0] init_dat,
   input  logic                 np_use,
   input  logic [HDR_FLD_W-1:0] hdr_shown,
   input  logic [DAT_FLD_W-1:0] dat_shown,
   input  logic [DAT_CNT_W-1:0] dat_cost,
   output logic                 hdr_one,
   output logic                 dat_one,
   output logic                 hdr_viol,
   output logic                 dat_viol
);
   logic hdr_over;
   logic dat_over;

   assign hdr_over = np_use && (hdr_shown == '0);
   assign dat_over = np_use && (dat_cost > DAT_CNT_W'(dat_shown));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hdr_one  <= 1'b0;
         dat_one  <= 1'b0;
         hdr_viol <= 1'b0;
         dat_viol <= 1'b0;
      end else begin
         if (init_valid) begin
            hdr_one <= (init_hdr == HDR_CNT_W'(1));
            dat_one <= (init_dat == DAT_CNT_W'(1));
         end
         if (hdr_over) hdr_viol <= 1'b1;
         if (dat_over) dat_viol <= 1'b1;
      end
   end
endmodule

// File: rtl/tx_credit_tracker.sv
module tx_credit_tracker
   import tcf_pkg::*;
#(
   parameter int HDR_CNT_W     = 8,
   parameter int DAT_CNT_W     = 12,
   parameter int HDR_FLD_W     = 4,
   parameter int DAT_FLD_W     = 8,
   parameter int LEN_W         = 10,
   parameter int DW_PER_CREDIT = 4
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       init_valid,
   input  logic [NUM_CLASS*HDR_CNT_W-1:0]             init_hdr_lim,
   input  logic [NUM_CLASS*DAT_CNT_W-1:0]             init_dat_lim,
   input  logic                                       upd_valid,
   input  logic [1:0]                                 upd_class,
   input  logic [HDR_CNT_W-1:0]                       upd_hdr,
   input  logic [DAT_CNT_W-1:0]                       upd_dat,
   input  logic                                       use_valid,
   input  logic [1:0]                                 use_class,
   input  logic [LEN_W-1:0]                           use_len_dw,
   output logic [NUM_CLASS*(HDR_FLD_W+DAT_FLD_W)-1:0] cred_view,
   output logic                                       np_hdr_one,
   output logic                                       np_dat_one,
   output logic                                       np_hdr_viol,
   output logic                                       np_dat_viol
);
   localparam int CLS_W  = HDR_FLD_W + DAT_FLD_W;
   localparam int VIEW_W = NUM_CLASS * CLS_W;

   if (VIEW_W != $bits(cred_view)) begin : g_bad_view
      $error("view width mismatch");
   end
   if (HDR_CNT_W < 2 || DAT_CNT_W < 2) begin : g_bad_cnt
      $error("counters must be at least two bits");
   end

   logic                 active_q;
   logic                 run_use;
   logic                 run_upd;
   logic [DAT_CNT_W-1:0] dat_cost;
   logic [HDR_FLD_W-1:0] hdr_shown [NUM_CLASS];
   logic [DAT_FLD_W-1:0] dat_shown [NUM_CLASS];

   always_ff @(posedge clk) begin
      if (!rst_n)          active_q <= 1'b0;
      else if (init_valid) active_q <= 1'b1;
   end

   assign run_use = use_valid && active_q && !init_valid;
   assign run_upd = upd_valid && active_q && !init_valid;

   tcf_cost #(
      .LEN_W        (LEN_W),
      .CNT_W        (DAT_CNT_W),
      .DW_PER_CREDIT(DW_PER_CREDIT)
   ) u_cost (
      .len_dw(use_len_dw),
      .cost  (dat_cost)
   );

   for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
      logic use_hit;
      logic upd_hit;
      assign use_hit = run_use && (use_class == 2'(c));
      assign upd_hit = run_upd && (upd_class == 2'(c));

      tcf_counter #(
         .CNT_W(HDR_CNT_W),
         .FLD_W(HDR_FLD_W)
      ) u_hdr (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (init_valid),
         .load_val(init_hdr_lim[c*HDR_CNT_W +: HDR_CNT_W]),
         .add_en  (upd_hit),
         .add_val (upd_hdr),
         .sub_en  (use_hit),
         .sub_val (HDR_CNT_W'(1)),
         .shown   (hdr_shown[c]),
         .view_q  (cred_view[c*CLS_W +: HDR_FLD_W])
      );

      tcf_counter #(
         .CNT_W(DAT_CNT_W),
         .FLD_W(DAT_FLD_W)
      ) u_dat (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (init_valid),
         .load_val(init_dat_lim[c*DAT_CNT_W +: DAT_CNT_W]),
         .add_en  (upd_hit),
         .add_val (upd_dat),
         .sub_en  (use_hit),
         .sub_val (dat_cost),
         .shown   (dat_shown[c]),
         .view_q  (cred_view[c*CLS_W+HDR_FLD_W +: DAT_FLD_W])
      );
   end

   tcf_np_monitor #(
      .HDR_CNT_W(HDR_CNT_W),
      .DAT_CNT_W(DAT_CNT_W),
      .HDR_FLD_W(HDR_FLD_W),
      .DAT_FLD_W(DAT_FLD_W)
   ) u_np (
      .clk       (clk),
      .rst_n     (rst_n),
      .init_valid(init_valid),
      .init_hdr  (init_hdr_lim[int'(CLS_NONPOST)*HDR_CNT_W +: HDR_CNT_W]),
      .init_dat  (init_dat_lim[int'(CLS_NONPOST)*DAT_CNT_W +: DAT_CNT_W]),
      .np_use    (run_use && (use_class == CLS_NONPOST)),
      .hdr_shown (hdr_shown[int'(CLS_NONPOST)]),
      .dat_shown (dat_shown[int'(CLS_NONPOST)]),
      .dat_cost  (dat_cost),
      .hdr_one   (np_hdr_one),
      .dat_one   (np_dat_one),
      .hdr_viol  (np_hdr_viol),
      .dat_viol  (np_dat_viol)
   );
endmodule

// File: rtl/tcf_checker.sv
module tcf_checker #(
   parameter int HDR_CNT_W = 8,
   parameter int VIEW_W    = 36
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   init_valid,
   input logic [3*HDR_CNT_W-1:0] init_hdr_lim,
   input logic                   upd_valid,
   input logic                   use_valid,
   input logic [VIEW_W-1:0]      cred_view,
   input logic                   np_hdr_one,
   input logic                   np_dat_one,
   input logic                   np_hdr_viol,
   input logic                   np_dat_viol
);
   logic [1:0] cyc;
   logic       seen_init;
   logic       any_ev;

   assign any_ev = init_valid || upd_valid || use_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cyc       <= '0;
         seen_init <= 1'b0;
      end else begin
         if (cyc != 2'd3) cyc <= cyc + 2'd1;
         if (init_valid)  seen_init <= 1'b1;
      end
   end

   assert_hdr_viol_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      np_hdr_viol |=> np_hdr_viol);

   assert_dat_viol_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      np_dat_viol |=> np_dat_viol);

   assert_one_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc != 2'd0 && !init_valid) |=> $stable({np_hdr_one, np_dat_one}));

   assert_one_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      init_valid |=> (np_hdr_one == ($past(init_hdr_lim[HDR_CNT_W +: HDR_CNT_W]) == HDR_CNT_W'(1))));

   assert_idle_view_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_init |-> (cred_view == '0));

   assert_quiet_view_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd3 && !$past(any_ev, 2)) |-> $stable(cred_view));
endmodule

bind tx_credit_tracker tcf_checker #(
   .HDR_CNT_W(HDR_CNT_W),
   .VIEW_W   (tcf_pkg::NUM_CLASS*(HDR_FLD_W+DAT_FLD_W))
) u_tcf_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .init_valid  (init_valid),
   .init_hdr_lim(init_hdr_lim),
   .upd_valid   (upd_valid),
   .use_valid   (use_valid),
   .cred_view   (cred_view),
   .np_hdr_one  (np_hdr_one),
   .np_dat_one  (np_dat_one),
   .np_hdr_viol (np_hdr_viol),
   .np_dat_viol (np_dat_viol)
);

// File: tb/tx_credit_tracker_test.sv
`timescale 1ns/1ps
module tx_credit_tracker_test;
   localparam int HM = 255;
   localparam int DM = 4095;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        init_valid;
   logic [23:0] init_hdr_lim;
   logic [35:0] init_dat_lim;
   logic        upd_valid;
   logic [1:0]  upd_class;
   logic [7:0]  upd_hdr;
   logic [11:0] upd_dat;
   logic        use_valid;
   logic [1:0]  use_class;
   logic [9:0]  use_len_dw;
   logic [35:0] cred_view;
   logic        np_hdr_one, np_dat_one, np_hdr_viol, np_dat_viol;

   int total = 0;
   int fails = 0;

   int  hl[3], hu[3], dl[3], du[3];
   bit  act, m_h1, m_d1, m_hv, m_dv;

   always #2.5 clk = ~clk;

   tx_credit_tracker uut (
      .clk(clk), .rst_n(rst_n), .init_valid(init_valid),
      .init_hdr_lim(init_hdr_lim), .init_dat_lim(init_dat_lim),
      .upd_valid(upd_valid), .upd_class(upd_class), .upd_hdr(upd_hdr), .upd_dat(upd_dat),
      .use_valid(use_valid), .use_class(use_class), .use_len_dw(use_len_dw),
      .cred_view(cred_view), .np_hdr_one(np_hdr_one), .np_dat_one(np_dat_one),
      .np_hdr_viol(np_hdr_viol), .np_dat_viol(np_dat_viol)
   );

   function automatic int sat_h(int c);
      int a = (hl[c] - hu[c]) & HM;
      return (a > 15) ? 15 : a;
   endfunction

   function automatic int sat_d(int c);
      int a = (dl[c] - du[c]) & DM;
      return (a > 255) ? 255 : a;
   endfunction

   function automatic logic [35:0] model_view();
      logic [35:0] v = '0;
      for (int c = 0; c < 3; c++) begin
         v[c*12 +: 4]   = 4'(sat_h(c));
         v[c*12+4 +: 8] = 8'(sat_d(c));
      end
      return v;
   endfunction

   task automatic chk(bit ok, string tag, logic [63:0] a, logic [63:0] e);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
      end
   endtask

   task automatic model_reset();
      for (int c = 0; c < 3; c++) begin hl[c] = 0; hu[c] = 0; dl[c] = 0; du[c] = 0; end
      act = 0; m_h1 = 0; m_d1 = 0; m_hv = 0; m_dv = 0;
   endtask

   task automatic idle_inputs();
      init_valid = 0; upd_valid = 0; use_valid = 0;
      upd_class = 0; upd_hdr = 0; upd_dat = 0; use_class = 0; use_len_dw = 0;
   endtask

   // Inputs are already driven; advance one clock and compare with the model.
   task automatic tick(string tag);
      logic [35:0] ev;
      int cost, c;
      ev = model_view();
      if (init_valid) begin
         for (int k = 0; k < 3; k++) begin
            hl[k] = int'(init_hdr_lim[k*8 +: 8]); hu[k] = 0;
            dl[k] = int'(init_dat_lim[k*12 +: 12]); du[k] = 0;
         end
         act = 1; m_h1 = (hl[1] == 1); m_d1 = (dl[1] == 1);
      end else if (act) begin
         cost = (int'(use_len_dw) + 3) / 4;
         if (use_valid && use_class == 2'd1) begin
            if (sat_h(1) == 0) m_hv = 1;
            if (cost > sat_d(1)) m_dv = 1;
         end
         if (upd_valid && upd_class != 2'd3) begin
            c = int'(upd_class);
            hl[c] = (hl[c] + int'(upd_hdr)) & HM;
            dl[c] = (dl[c] + int'(upd_dat)) & DM;
         end
         if (use_valid && use_class != 2'd3) begin
            c = int'(use_class);
            hu[c] = (hu[c] + 1) & HM;
            du[c] = (du[c] + cost) & DM;
         end
      end
      @(posedge clk);
      @(negedge clk);
      chk(cred_view == ev, {tag, " view"}, 64'(cred_view), 64'(ev));
      chk({np_hdr_one, np_dat_one, np_hdr_viol, np_dat_viol} == {m_h1, m_d1, m_hv, m_dv},
          {tag, " flags"}, 64'({np_hdr_one, np_dat_one, np_hdr_viol, np_dat_viol}),
          64'({m_h1, m_d1, m_hv, m_dv}));
      idle_inputs();
   endtask

   task automatic do_init(int h0, int h1, int h2, int d0, int d1, int d2);
      init_valid   = 1;
      init_hdr_lim = {8'(h2), 8'(h1), 8'(h0)};
      init_dat_lim = {12'(d2), 12'(d1), 12'(d0)};
   endtask

   task automatic do_use(int c, int len);
      use_valid = 1; use_class = 2'(c); use_len_dw = 10'(len);
   endtask

   task automatic do_upd(int c, int h, int d);
      upd_valid = 1; upd_class = 2'(c); upd_hdr = 8'(h); upd_dat = 12'(d);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      void'($urandom(32'h00C0FFEE));
      idle_inputs();
      init_hdr_lim = '0; init_dat_lim = '0;
      model_reset();
      rst_n = 0;
      repeat (3) @(negedge clk);
      chk(cred_view == '0, "R1 reset view", 64'(cred_view), 0);
      rst_n = 1;
      tick("R1 after reset");

      // R2: events before initialization are ignored
      do_upd(0, 9, 50); do_use(1, 8); tick("R2 early events");
      do_use(1, 8); tick("R2 early use");
      tick("R2 idle");

      // R3 R6 R7: load with saturating posted limits and single-credit NP limits
      do_init(20, 1, 5, 300, 1, 40); tick("R3 R7 init");
      tick("R3 R6 view settles");
      tick("R3 R6 view held");

      // R4: cost rounding and class 3
      do_use(0, 17); tick("R4 posted len 17");
      do_use(2, 0);  tick("R4 cpl zero length");
      do_use(3, 64); tick("R4 class three ignored");
      tick("R4 settle");

      // R8: first NP use fits, second overspends; header wraps (R10)
      do_use(1, 4); tick("R8 np within budget");
      tick("R8 settle");
      do_use(1, 1); tick("R8 R10 np overspend");
      tick("R8 R10 wrap saturates");

      // R5: update and use together, same class
      do_upd(2, 3, 10); do_use(2, 12); tick("R5 same class collision");
      do_upd(0, 2, 4); do_use(2, 5); tick("R5 cross class");
      tick("R5 settle");

      // R9 R7 R8: init collides with use; flags re-evaluated; violations kept
      do_init(10, 2, 10, 100, 2, 100); do_use(1, 400); do_upd(1, 1, 1);
      tick("R9 R7 R8 init collision");
      tick("R9 settle");

      // random phase
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(0, 299) == 0)
            do_init($urandom_range(0, 40), $urandom_range(0, 3), $urandom_range(0, 40),
                    $urandom_range(0, 600), $urandom_range(0, 3), $urandom_range(0, 600));
         if ($urandom_range(0, 2) == 0)
            do_upd($urandom_range(0, 3), $urandom_range(0, 12), $urandom_range(0, 200));
         if ($urandom_range(0, 1) == 0)
            do_use($urandom_range(0, 3),
                   ($urandom_range(0, 3) == 0) ? $urandom_range(0, 1023) : $urandom_range(0, 40));
         tick("R4 R5 R6 R10 random");
      end

      // R1: reset clears sticky flags
      rst_n = 0; model_reset();
      @(posedge clk); @(negedge clk);
      rst_n = 1;
      tick("R1 reset mid-run");

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule